// File: doc/BRIEF.md
# Page Translation Unit with Associative Cache

This block turns a virtual address into a physical address. The virtual address is split into a page number and a 12-bit byte offset. The page number is first matched against a small, fully associative cache of recent translations, and every slot is compared in the same cycle. On a match, the cached frame number is returned without touching memory.

When no slot matches, the block reads exactly one entry from a single-level page table in memory. The table's start address and its number of entries come in as inputs. A page number outside the table produces a fault and causes no memory read. An entry whose valid bit is clear also produces a fault. A valid entry is written into the cache and its frame is returned. Slots are refilled in round-robin order. A flush input empties the whole cache in one cycle.

One translation is in flight at a time. The memory side is a request/grant port followed by a read-data strobe, with at most one read outstanding.

Top module: `tlb_xlate_unit`

## Requirements
- R1: A page number below `pt_len` that matches a cached translation produces `rsp_valid` on the second rising edge after the request is accepted, and raises no `mem_req` for that request.
- R2: A successful response carries `rsp_paddr` = {frame number, original low 12 bits of `req_vaddr`} and `rsp_fault` = 0.
- R3: A page number greater than or equal to `pt_len` produces a fault response on the second rising edge after acceptance, with `rsp_paddr` = 0 and no memory read. This holds whether or not the page is cached.
- R4: A page number below `pt_len` that is not cached causes exactly one memory read at address `pt_base + page_number*4`. `mem_req` and `mem_addr` stay steady until `mem_gnt`, and no new request is raised until `mem_rvalid` returns.
- R5: A table entry has its valid flag in bit 31 and the frame number in bits 19:0. An entry with bit 31 clear gives a fault response with `rsp_paddr` = 0 and is not cached, so the same page misses again.
- R6: A table entry with bit 31 set is cached, so the next access to the same page hits. No page is ever held in two slots.
- R7: The cache has 8 slots, and fills go to slots in round-robin order. After 8 distinct fills following a flush, the 9th fill evicts the page from the first fill.
- R8: `flush` held for one cycle invalidates every slot, so the next access to any page misses.
- R9: When `flush` and the `mem_rvalid` of a fill fall in the same cycle, the response is still delivered correctly, the fetched entry is not kept, and the round-robin position does not advance.
- R10: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the cache is empty.
- R11: `req_ready` is 0 from acceptance until the response, and `rsp_valid` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| pt_base | input | 32 | Byte address of the page table |
| pt_len | input | 21 | Number of entries in the page table |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_req | output | 1 | Table read request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Table entry byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry read data |

## Verification
Two things can fall in the same cycle: a flush and the read data that completes a cache fill. The bench forces the overlap by making its memory model raise `flush` on the very edge where it drives `mem_rvalid`. It then checks that the translation just fetched is still correct, and that a repeat access to that page reads memory again. A reference model of the cache, kept with a round-robin pointer that does not advance on the overlap, predicts hit or miss for every later request. Random traffic with occasional flushes and changing table lengths exercises the same overlap and the bounds check against cached pages.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_LOOKUP = 2'd1,
      WK_MREQ   = 2'd2,
      WK_MWAIT  = 2'd3
   } walk_state_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 20,
   parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [ENTRIES-1:0] match;

   initial begin
      assert (ENTRIES >= 2) else $error("tlb_cam: ENTRIES must be at least 2");
      assert ((1 << IDX_W) >= ENTRIES) else $error("tlb_cam: IDX_W too narrow");
   end

   // Parallel comparators, one per slot.
   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_cmp
         assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
      end
   endgenerate

   assign hit = |match;

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_data = hit_data | data_q[i];
      end
   end

   // Flush wins over a simultaneous write.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_idx == IDX_W'(i)) begin
               tag_q[i]  <= wr_tag;
               data_q[i] <= wr_data;
            end
         end
      end
   end

   // R6: a page is never resident in two slots
   a_r6_single_match : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8: after a flush nothing matches
   a_r8_flush_empties : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] ptr_q;

   initial begin
      assert (ENTRIES >= 2) else $error("tlb_victim_ptr: ENTRIES must be at least 2");
   end

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)       ptr_q <= '0;
            else if (advance) ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) ptr_q <= '0;
            else if (advance) begin
               if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
               else                              ptr_q <= ptr_q + 1'b1;
            end
         end
      end
   endgenerate

   assign ptr = ptr_q;

   // R7: each fill moves the victim slot on
   a_r7_ptr_moves : assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> ptr_q != $past(ptr_q));

   // R9: no fill, no movement
   a_r9_ptr_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q));

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
   import tlb_xlate_pkg::*;
#(
   parameter int VA_W          = 32,
   parameter int OFF_W         = 12,
   parameter int PFN_W         = 20,
   parameter int MEM_AW        = 32,
   parameter int MEM_DW        = 32,
   parameter int PTE_BYTES     = 4,
   parameter int PTE_VALID_BIT = 31,
   localparam int VPN_W        = VA_W - OFF_W,
   localparam int LEN_W        = VPN_W + 1,
   localparam int PA_W         = PFN_W + OFF_W,
   localparam int PTE_SHIFT    = $clog2(PTE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [MEM_AW-1:0] pt_base,
   input  logic [LEN_W-1:0]  pt_len,
   output logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_hit,
   input  logic [PFN_W-1:0]  lk_pfn,
   output logic              fill_en,
   output logic [PFN_W-1:0]  fill_pfn,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [MEM_DW-1:0] mem_rdata
);

   walk_state_e      state_q;
   logic [VA_W-1:0]  vaddr_q;
   logic [VPN_W-1:0] vpn;
   logic [OFF_W-1:0] off;
   logic             in_range;
   logic             pte_ok;
   logic [PFN_W-1:0] pte_pfn;

   assign vpn      = vaddr_q[VA_W-1:OFF_W];
   assign off      = vaddr_q[OFF_W-1:0];
   assign lk_vpn   = vpn;
   assign in_range = {1'b0, vpn} < pt_len;

   assign req_ready = (state_q == WK_IDLE);
   assign mem_req   = (state_q == WK_MREQ);
   assign mem_addr  = pt_base + (MEM_AW'(vpn) << PTE_SHIFT);

   assign pte_ok   = mem_rdata[PTE_VALID_BIT];
   assign pte_pfn  = mem_rdata[PFN_W-1:0];
   assign fill_en  = (state_q == WK_MWAIT) && mem_rvalid && pte_ok;
   assign fill_pfn = pte_pfn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= WK_IDLE;
         vaddr_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  state_q <= WK_LOOKUP;
               end
            end
            WK_LOOKUP: begin
               if (!in_range) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b1;
                  rsp_paddr <= '0;
                  state_q   <= WK_IDLE;
               end else if (lk_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_paddr <= {lk_pfn, off};
                  state_q   <= WK_IDLE;
               end else begin
                  state_q   <= WK_MREQ;
               end
            end
            WK_MREQ: begin
               if (mem_gnt) state_q <= WK_MWAIT;
            end
            WK_MWAIT: begin
               if (mem_rvalid) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= !pte_ok;
                  rsp_paddr <= pte_ok ? {pte_pfn, off} : '0;
                  state_q   <= WK_IDLE;
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   // R1: a cached, in-range page answers next cycle without a table read
   a_r1_hit_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_LOOKUP && in_range && lk_hit) |=> (rsp_valid && !rsp_fault && !mem_req));

   // R3: an out-of-range page faults at once with no read
   a_r3_bound_fault : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_LOOKUP && !in_range) |=> (rsp_valid && rsp_fault && !mem_req));

   // R3: faults carry a zero address
   a_r3_fault_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   // R4: request and address held until granted
   a_r4_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R4: no second request while a read is outstanding
   a_r4_one_outstanding : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !mem_req);

   // R11: single-cycle response strobe
   a_r11_rsp_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R11: busy after acceptance
   a_r11_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit #(
   parameter int VA_W          = 32,
   parameter int OFF_W         = 12,
   parameter int PFN_W         = 20,
   parameter int TLB_ENTRIES   = 8,
   parameter int MEM_AW        = 32,
   parameter int MEM_DW        = 32,
   parameter int PTE_BYTES     = 4,
   parameter int PTE_VALID_BIT = 31,
   localparam int VPN_W        = VA_W - OFF_W,
   localparam int LEN_W        = VPN_W + 1,
   localparam int PA_W         = PFN_W + OFF_W,
   localparam int IDX_W        = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [MEM_AW-1:0] pt_base,
   input  logic [LEN_W-1:0]  pt_len,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [MEM_DW-1:0] mem_rdata
);

   initial begin
      assert (OFF_W > 0 && OFF_W < VA_W) else $error("tlb_xlate_unit: bad OFF_W");
      assert (PTE_VALID_BIT < MEM_DW) else $error("tlb_xlate_unit: valid bit outside entry");
      assert (PFN_W <= PTE_VALID_BIT) else $error("tlb_xlate_unit: frame overlaps valid bit");
      assert ((PTE_BYTES & (PTE_BYTES - 1)) == 0) else $error("tlb_xlate_unit: PTE_BYTES not a power of two");
      assert (TLB_ENTRIES >= 2) else $error("tlb_xlate_unit: need at least two slots");
   end

   logic [VPN_W-1:0] lk_vpn;
   logic             lk_hit;
   logic [PFN_W-1:0] lk_pfn;
   logic             fill_en;
   logic [PFN_W-1:0] fill_pfn;
   logic [IDX_W-1:0] victim;
   logic             fill_kept;

   assign fill_kept = fill_en && !flush;

   tlb_walker #(
      .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MEM_AW(MEM_AW),
      .MEM_DW(MEM_DW), .PTE_BYTES(PTE_BYTES), .PTE_VALID_BIT(PTE_VALID_BIT)
   ) u_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .pt_base(pt_base), .pt_len(pt_len),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .fill_en(fill_en), .fill_pfn(fill_pfn),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   tlb_cam #(
      .ENTRIES(TLB_ENTRIES), .TAG_W(VPN_W), .DATA_W(PFN_W), .IDX_W(IDX_W)
   ) u_cam (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_tag(lk_vpn), .hit(lk_hit), .hit_data(lk_pfn),
      .wr_en(fill_en), .wr_idx(victim), .wr_tag(lk_vpn), .wr_data(fill_pfn)
   );

   tlb_victim_ptr #(
      .ENTRIES(TLB_ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk(clk), .rst_n(rst_n), .advance(fill_kept), .ptr(victim)
   );

endmodule

// File: tb/tlb_xlate_unit_tb.sv
`timescale 1ns/1ps
module tlb_xlate_unit_tb;

   localparam logic [31:0] BASE = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush;
   logic        flush_t = 1'b0;
   logic        flush_m = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] pt_base = BASE;
   logic [20:0] pt_len = 21'd64;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req;
   logic        mem_gnt;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   assign flush = flush_t | flush_m;

   always #2.5 clk = ~clk;

   tlb_xlate_unit u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .pt_base(pt_base), .pt_len(pt_len),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // Page table content, computed from the entry address.
   function automatic logic [31:0] pte_of(input logic [31:0] addr);
      logic [31:0] vpn;
      logic [19:0] frm;
      vpn = (addr - BASE) >> 2;
      frm = 20'(vpn * 32'h9E37 + 32'h1234);
      return {((vpn % 7) != 3), 11'd0, frm};
   endfunction

   // Memory model: random grant, random read latency.
   logic        gnt_en = 1'b0;
   bit          pend = 0;
   int          dly = 0;
   logic [31:0] pend_addr = '0;
   logic [31:0] last_addr = '0;
   int          rd_cnt = 0;
   int          overlap_err = 0;
   bit          collide_req = 0;

   assign mem_gnt = mem_req & gnt_en;

   always @(posedge clk) begin
      gnt_en     <= ($urandom % 3) != 0;
      mem_rvalid <= 1'b0;
      flush_m    <= 1'b0;
      if (!rst_n) begin
         pend <= 0;
      end else if (pend) begin
         if (mem_req) overlap_err <= overlap_err + 1;
         if (dly == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= pte_of(pend_addr);
            flush_m    <= collide_req;
            pend       <= 0;
         end else begin
            dly <= dly - 1;
         end
      end else if (mem_req && mem_gnt) begin
         pend      <= 1;
         pend_addr <= mem_addr;
         last_addr <= mem_addr;
         dly       <= $urandom % 4;
         rd_cnt    <= rd_cnt + 1;
      end
   end

   // Reference cache state.
   bit          m_v   [8];
   logic [19:0] m_vpn [8];
   int          m_ptr = 0;

   function automatic bit m_hit(input logic [19:0] vpn);
      for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return 1;
      return 0;
   endfunction

   function automatic void m_clear();
      for (int i = 0; i < 8; i++) m_v[i] = 0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush_t = 1'b1;
      @(negedge clk);
      flush_t = 1'b0;
      m_clear();
   endtask

   task automatic xlate(input logic [31:0] va, input string tag);
      logic [19:0] vpn;
      bit          inr, exp_hit, exp_fault;
      logic [31:0] pte, exp_pa;
      int          r0, w, exp_reads;
      vpn       = va[31:12];
      inr       = {1'b0, vpn} < pt_len;
      exp_hit   = inr && m_hit(vpn);
      pte       = pte_of(BASE + {vpn, 2'b00});
      exp_reads = (inr && !exp_hit) ? 1 : 0;
      exp_fault = !inr || (exp_reads == 1 && !pte[31]);
      exp_pa    = exp_fault ? 32'd0 : {pte[19:0], va[11:0]};
      r0        = rd_cnt;
      @(negedge clk);
      check(req_ready == 1'b1, {tag, " R11 ready before request"}, 64'(req_ready), 64'd1);
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, {tag, " R11 busy after accept"}, 64'(req_ready), 64'd0);
      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!rsp_valid && w < 200);
      check(rsp_fault == exp_fault, {tag, " R3/R5 fault"}, 64'(rsp_fault), 64'(exp_fault));
      check(rsp_paddr == exp_pa, {tag, " R2 paddr"}, 64'(rsp_paddr), 64'(exp_pa));
      check((rd_cnt - r0) == exp_reads, {tag, " R1/R4 read count"}, 64'(rd_cnt - r0), 64'(exp_reads));
      if (exp_reads == 1)
         check(last_addr == BASE + {vpn, 2'b00}, {tag, " R4 entry address"}, 64'(last_addr), 64'(BASE + {vpn, 2'b00}));
      else
         check(w == 1, {tag, " R1/R3 one-cycle answer"}, 64'(w), 64'd1);
      @(negedge clk);
      check(rsp_valid == 1'b0, {tag, " R11 single pulse"}, 64'(rsp_valid), 64'd0);
      if (exp_reads == 1 && pte[31]) begin
         if (collide_req) begin
            m_clear();
         end else begin
            m_v[m_ptr]   = 1;
            m_vpn[m_ptr] = vpn;
            m_ptr        = (m_ptr + 1) % 8;
         end
      end else if (collide_req && exp_reads == 1) begin
         m_clear();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_clear();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
      check(mem_req == 1'b0, "R10 mem_req", 64'(mem_req), 64'd0);

      pt_len = 21'd64;
      xlate({20'd5, 12'h123}, "R10 first access misses / R4");
      xlate({20'd5, 12'hABC}, "R1 R6 hit after fill");
      xlate({20'd3, 12'h010}, "R5 invalid entry");
      xlate({20'd3, 12'h010}, "R5 invalid not cached");
      xlate({20'd64, 12'h000}, "R3 at length");
      xlate({20'd63, 12'hFFF}, "R3 last legal page");
      pt_len = 21'd5;
      xlate({20'd5, 12'h001}, "R3 cached page beyond length");
      pt_len = 21'd64;

      do_flush();
      xlate({20'd5, 12'h002}, "R8 miss after flush");

      // R7: round-robin eviction
      do_flush();
      for (int i = 0; i < 8; i++) xlate({20'(i * 7), 12'h055}, "R7 fill");
      for (int i = 0; i < 8; i++) xlate({20'(i * 7), 12'h066}, "R7 all resident");
      xlate({20'd56, 12'h077}, "R7 ninth fill");
      xlate({20'd0, 12'h088}, "R7 oldest evicted");

      // R9: flush on the same cycle as the fill data
      do_flush();
      collide_req = 1;
      xlate({20'd14, 12'h0F0}, "R9 collide response");
      collide_req = 0;
      xlate({20'd14, 12'h0F1}, "R9 entry dropped");
      xlate({20'd14, 12'h0F2}, "R9 refill hits next");

      // Random traffic
      for (int n = 0; n < 400; n++) begin
         int unsigned sel;
         sel = $urandom % 20;
         if (sel == 0) do_flush();
         if (sel == 1) pt_len = 21'(16 + ($urandom % 30));
         collide_req = (sel == 2);
         xlate({20'($urandom % 40), 12'($urandom)}, "random");
         collide_req = 0;
      end

      check(overlap_err == 0, "R4 one outstanding read", 64'(overlap_err), 64'd0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule